// File: doc/BRIEF.md
# Reloading Timer/Event Down-Counter

This block is a 16-bit down-counter with a reload register. It counts one of two sources. In timer mode the source is a one-cycle tick pulse from an external prescaler. In event mode the source is edges on an asynchronous pin, and the edge polarity can be set. When the counter is at zero and an enabled count arrives, it takes the reload value instead of decrementing. One cycle later it raises a one-cycle interrupt request pulse. A counting cycle of N+1 source counts therefore follows a reload value of N.

Software uses a small register bus with three registers: control, mode and count.

- Control holds the start bit, which can be written at any time.
- Mode selects the source and the edge polarity. Writes to mode are accepted only while the counter is stopped.
- A write to count while stopped loads both the counter and the reload register. A write to count while running changes only the reload register.
- A read of count returns the live value. A read issued in the same cycle as a reload returns all-ones.

Each read is answered one cycle later by a single-cycle `rd_valid` strobe. The answer cannot be back-pressured, so a master that issues a read must accept the response in that following cycle. Writes complete in the cycle they are presented.

Top module: `evt_down_timer`

## Requirements
- R1: After reset, start is 0, mode is 0, the counter and reload register are 0, and both `irq` and `rd_valid` are low.
- R2: A write to the mode register (address 1) while start is 1 is ignored, and mode reads back its previous value.
- R3: While start is 0, the counter changes only through a count-register write; ticks and edges leave it unchanged.
- R4: In timer mode (mode bits [1:0] = 2'b00), while running, each cycle with `tick_in` high decrements the counter by one.
- R5: A count-register write (address 2) while stopped loads both the counter and the reload register, and a read then returns the written value until counting begins.
- R6: An enabled count that finds the counter at zero loads the reload value, and `irq` is high for exactly the following cycle.
- R7: A count-register write while running updates only the reload register. The live count is unchanged, and the new value is used at the next reload.
- R8: A count read issued in the same cycle as a reload returns 16'hFFFF.
- R9: In event mode (mode bits [1:0] = 2'b01), `tick_in` is ignored. Edges on `ext_in` are counted after a two-flop synchronizer. Polarity is set by mode bits [3:2]: 2'b00 counts rising edges, 2'b01 counts falling edges, and 2'b10 or 2'b11 counts both.
- R10: `rd_valid` is high exactly one cycle after a cycle with `bus_rd` high. The read data is as follows:
  - address 0 returns the start bit in bit 0;
  - address 1 returns the mode bits in [3:0];
  - address 2 returns the count;
  - address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Prescaled tick pulse, the timer-mode source |
| ext_in | input | 1 | Asynchronous event pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 mode, 2 count |
| bus_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read response strobe, one cycle after `bus_rd` |
| rd_data | output | 16 | Read response data |
| irq | output | 1 | One-cycle interrupt request after a reload |

## Verification
Two functions can land in the same cycle: a read of the count register and a reload. The bench brings the counter to zero and then asserts `tick_in` and a count read in the same cycle. That response must be 16'hFFFF. The next read must return the reload value that a running-mode write placed there earlier.

A second collision is a count write while running. It must leave the live count readable as before and surface only at the following reload. The scoreboard judges both cases from values queued at read issue.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W = 16;

  typedef enum logic [1:0] {
    SRC_TICK  = 2'b00,
    SRC_EVENT = 2'b01,
    SRC_RSV2  = 2'b10,
    SRC_RSV3  = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    POL_RISE = 2'b00,
    POL_FALL = 2'b01,
    POL_ANY  = 2'b10,
    POL_ANY2 = 2'b11
  } edge_pol_e;

  typedef enum logic [1:0] {
    ADR_CTRL  = 2'b00,
    ADR_MODE  = 2'b01,
    ADR_COUNT = 2'b10,
    ADR_NONE  = 2'b11
  } reg_adr_e;

  typedef struct packed {
    edge_pol_e pol;
    src_sel_e  src;
  } mode_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync
  import tmr_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_async,
  input  edge_pol_e pol,
  output logic      edge_hit
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= pin_async;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= synced;
  end

  always_comb begin
    unique case (pol)
      POL_RISE: edge_hit = synced & ~last_q;
      POL_FALL: edge_hit = ~synced & last_q;
      default:  edge_hit = synced ^ last_q;
    endcase
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         count_pulse,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] cnt_val,
  output logic         reload_now,
  output logic         irq
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] rel_q;
  logic         irq_q;
  logic         step;

  assign step       = run & count_pulse;
  assign reload_now = step & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= '0;
    else if (cnt_wr) rel_q <= cnt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run && cnt_wr) begin
      cnt_q <= cnt_wdata;
    end else if (step) begin
      cnt_q <= reload_now ? rel_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= reload_now;
  end

  assign cnt_val = cnt_q;
  assign irq     = irq_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] cnt_val,
  input  logic         reload_now,
  output logic         run,
  output mode_t        mode,
  output logic         cnt_wr,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  localparam int unsigned MODE_W = $bits(mode_t);

  logic         run_q;
  mode_t        mode_q;
  logic         rvalid_q;
  logic [W-1:0] rdata_q;
  logic [W-1:0] rd_next;
  reg_adr_e     adr;

  assign adr    = reg_adr_e'(bus_addr);
  assign cnt_wr = bus_wr && (adr == ADR_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else if (bus_wr && adr == ADR_CTRL) run_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (bus_wr && adr == ADR_MODE && !run_q) mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
  end

  always_comb begin
    rd_next = '0;
    unique case (adr)
      ADR_CTRL:  rd_next[0] = run_q;
      ADR_MODE:  rd_next[MODE_W-1:0] = mode_q;
      ADR_COUNT: rd_next = reload_now ? '1 : cnt_val;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_next;
    end
  end

  assign run      = run_q;
  assign mode     = mode_q;
  assign rd_valid = rvalid_q;
  assign rd_data  = rdata_q;
endmodule

// File: rtl/evt_down_timer.sv
module evt_down_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W         = CNT_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_in,
  input  logic         ext_in,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  logic         run;
  mode_t        mode;
  logic         cnt_wr;
  logic [W-1:0] cnt_val;
  logic         reload_now;
  logic         edge_hit;
  logic         count_pulse;

  tmr_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cnt_val    (cnt_val),
    .reload_now (reload_now),
    .run        (run),
    .mode       (mode),
    .cnt_wr     (cnt_wr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  tmr_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ext_in),
    .pol       (mode.pol),
    .edge_hit  (edge_hit)
  );

  always_comb begin
    unique case (mode.src)
      SRC_TICK:  count_pulse = tick_in;
      SRC_EVENT: count_pulse = edge_hit;
      default:   count_pulse = 1'b0;
    endcase
  end

  tmr_count_core #(.W(W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .count_pulse (count_pulse),
    .cnt_wr      (cnt_wr),
    .cnt_wdata   (bus_wdata),
    .cnt_val     (cnt_val),
    .reload_now  (reload_now),
    .irq         (irq)
  );
endmodule

// File: rtl/evt_down_timer_chk.sv
module evt_down_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic [1:0]   bus_addr,
  input logic         run,
  input logic [3:0]   mode_bits,
  input logic         count_pulse,
  input logic [W-1:0] cnt_val,
  input logic         reload_now,
  input logic         rd_valid,
  input logic [W-1:0] rd_data,
  input logic         irq
);
  // R2
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode_bits));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(bus_wr && bus_addr == 2'b10)) |=> $stable(cnt_val));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count_pulse && cnt_val != '0) |=> cnt_val == $past(cnt_val) - 1'b1);

  // R6
  irq_after_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_now |=> irq);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_now |=> !irq);

  // R8
  reload_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'b10 && reload_now) |=> rd_data == '1);

  // R10
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);
endmodule

bind evt_down_timer evt_down_timer_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .run         (run),
  .mode_bits   (mode),
  .count_pulse (count_pulse),
  .cnt_val     (cnt_val),
  .reload_now  (reload_now),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .irq         (irq)
);

// File: tb/evt_down_timer_tb_top.sv
`timescale 1ns/1ps
module evt_down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        ext_in = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'b00;
  logic [15:0] bus_wdata = 16'h0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  evt_down_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .ext_in(ext_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read responses
  always @(negedge clk) begin
    if (rst_n && irq) irq_seen++;
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 16'h1, 16'h0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_in = 1'b1;
      repeat (4) @(negedge clk);
      ext_in = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq after reset", {15'b0, irq}, 16'h0);
    check("R1 rd_valid after reset", {15'b0, rd_valid}, 16'h0);
    rd(2'd0, 16'h0, "R1 ctrl reset");
    rd(2'd1, 16'h0, "R1 mode reset");
    rd(2'd2, 16'h0, "R1 count reset");
    rd(2'd3, 16'h0, "R10 unused address");
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'd5);
    rd(2'd2, 16'd5, "R5 written value before start");
    ticks(2);
    rd(2'd2, 16'd5, "R3 ticks while stopped");
    wr(2'd0, 16'h1);
    rd(2'd0, 16'h1, "R10 ctrl start bit");
    ticks(2);
    rd(2'd2, 16'd3, "R4 timer decrement");
    wr(2'd1, 16'h0001);
    rd(2'd1, 16'h0, "R2 mode write while running");
    ticks(3);
    rd(2'd2, 16'd0, "R4 reached zero");
    check("R6 no irq before reload", irq_seen[15:0], 16'd0);
    ticks(1);
    @(negedge clk);
    check("R6 irq pulse count", irq_seen[15:0], 16'd1);
    rd(2'd2, 16'd5, "R6 reloaded value");
    wr(2'd2, 16'd9);
    rd(2'd2, 16'd5, "R7 live count kept");
    ticks(5);
    // reload and read in the same cycle
    @(negedge clk);
    tick_in = 1'b1; bus_rd = 1'b1; bus_addr = 2'd2;
    exp_q.push_back(16'hFFFF); tag_q.push_back("R8 read during reload");
    @(negedge clk);
    tick_in = 1'b0; bus_rd = 1'b0;
    rd(2'd2, 16'd9, "R7 new reload used");
    check("R6 second irq", irq_seen[15:0], 16'd2);
    // event mode, rising
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0001);
    rd(2'd1, 16'h0001, "R10 mode readback");
    wr(2'd2, 16'd10);
    wr(2'd0, 16'h1);
    pulses(3);
    ticks(2);
    rd(2'd2, 16'd7, "R9 rising edges, ticks ignored");
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0005);
    wr(2'd0, 16'h1);
    pulses(2);
    rd(2'd2, 16'd5, "R9 falling edges");
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h0009);
    wr(2'd0, 16'h1);
    pulses(2);
    rd(2'd2, 16'd1, "R9 both edges");
    repeat (4) @(negedge clk);
    check("R10 all responses seen", exp_q.size(), 16'd0);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end
endmodule